// File: doc/BRIEF.md
# ECC-Protected SRAM Access Controller

This controller sits between a single-outstanding request port and a 137-bit-wide SRAM word (128 data bits and 9 check bits). A write that covers all sixteen bytes of an aligned word is encoded and stored in one SRAM cycle. Any narrower or misaligned write reads the word first, merges the enabled bytes, and stores the merged word with freshly computed check bits. Reads are checked with a SECDED code taken over the data and word-address bits 21:4. The error class decides what the requester gets back and whether the word is repaired in place.

Protection is chosen for each access by a 3-bit mode input and a 20-bit region mask, with one mask bit for each 128 KiB region. Accesses that are not protected skip checking and store an all-zero check field. In the cycle a read word is checked, the block raises one pulse per error class for an external logging unit, along with the word index. On a read with an uncorrectable error it can also flag an error on the response.

Top module: `ecc_sram_ctl`

## Requirements
- R1: A protected write with all byte enables set and `req_addr_i[3:0]==0` is a single SRAM write of {check, data}, and its response arrives 2 cycles after acceptance. Check bit j (j<8) is the XOR of the info bits whose position has bit j set. Info bit k (data bits 0..127, then address bits 4..21) takes the k-th integer in 3..154 that is not a power of two. Check bit 8 is the even parity of all info bits and check bits 0..7.
- R2: Any other write reads the word, replaces only the enabled bytes, and writes the whole word back with recomputed check bits. The response arrives 4 cycles after acceptance.
- R3: A read of a clean protected word returns the stored data 3 cycles after acceptance. It raises no error pulse and causes no SRAM write.
- R4: A single data-bit error returns corrected data and pulses `err_data_o`. With `auto_corr_i` set, the word is rewritten with `sram_wsel_o`=2'b11 (data and check).
- R5: With `auto_corr_i` clear, a single data-bit error still returns corrected data, but the SRAM is not written.
- R6: A single error in an address bit or a check bit returns the data unchanged and pulses `err_addr_o` or `err_chk_o`. Only the regenerated check field is rewritten (`sram_wsel_o`=2'b10).
- R7: A double error returns the raw data, pulses `err_ded_o`, and leaves the SRAM untouched.
- R8: `rsp_err_o` is set on a read response with a double error only while `err_resp_en_i` is set.
- R9: Mode 2 protects every address. Mode 3 protects an address only when `region_en_i[addr[21:17]]` is set. All other mode values protect nothing.
- R10: An unprotected write stores zero check bits. An unprotected read returns raw data with no error pulse.
- R11: After reset, `req_ready_o` is 1 and no SRAM access is made. `req_ready_o` stays low from acceptance until the one-cycle response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Byte address |
| req_wdata_i | input | 128 | Write data, lane-aligned to the word |
| req_be_i | input | 16 | Byte enables |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | 128 | Read data (zero for writes) |
| rsp_err_o | output | 1 | Uncorrectable read flag |
| mode_i | input | 3 | Protection mode |
| region_en_i | input | 20 | Per-region protection mask |
| auto_corr_i | input | 1 | Enable in-place data repair |
| err_resp_en_i | input | 1 | Enable error response |
| sram_req_o | output | 1 | SRAM access strobe |
| sram_we_o | output | 1 | SRAM write |
| sram_wsel_o | output | 2 | Write select: bit 0 data field, bit 1 check field |
| sram_addr_o | output | 18 | SRAM word index |
| sram_wdata_o | output | 137 | {check, data} to write |
| sram_rdata_i | input | 137 | {check, data}, one cycle after a read |
| err_data_o | output | 1 | Single data-bit error pulse |
| err_addr_o | output | 1 | Single address-bit error pulse |
| err_chk_o | output | 1 | Single check-bit error pulse |
| err_ded_o | output | 1 | Double error pulse |
| err_idx_o | output | 18 | Word index of the checked access |

## Verification
The assertions assume that the SRAM returns read data exactly one cycle after a read strobe. They also assume that the mode, mask and enable inputs do not change while an access is in progress. The bench models the SRAM with that fixed latency and changes configuration only between requests, after a response has been seen. Error injection edits the bench's memory model directly between accesses, so the request port never sees an illegal sequence.

// File: rtl/ecc_ctl_pkg.sv
package ecc_ctl_pkg;
  localparam int DATA_W  = 128;
  localparam int ADDR_W  = 22;
  localparam int LSB_W   = 4;
  localparam int IDX_W   = ADDR_W - LSB_W;
  localparam int INFO_W  = DATA_W + IDX_W;
  localparam int HAM_W   = 8;
  localparam int CHK_W   = HAM_W + 1;
  localparam int WORD_W  = DATA_W + CHK_W;
  localparam int BE_W    = DATA_W / 8;
  localparam int MAX_POS = INFO_W + HAM_W;

  localparam logic [2:0] MODE_FULL   = 3'd2;
  localparam logic [2:0] MODE_REGION = 3'd3;

  typedef enum logic [2:0] {
    ERR_NONE, ERR_DATA, ERR_ADDR, ERR_CHK, ERR_DED
  } err_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CHECK, ST_WRITE, ST_WBACK, ST_RESP
  } ctl_st_e;

  // info bits covered by Hamming check bit j
  function automatic logic [INFO_W-1:0] col_mask(input int j);
    logic [INFO_W-1:0] m;
    int k;
    m = '0;
    k = 0;
    for (int p = 3; p <= MAX_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (((p >> j) & 1) != 0) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder import ecc_ctl_pkg::*; (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [INFO_W-1:0] info;
  logic [HAM_W-1:0]  ham;

  assign info = {idx_i, data_i};

  for (genvar j = 0; j < HAM_W; j++) begin : g_col
    localparam logic [INFO_W-1:0] MASK = col_mask(j);
    assign ham[j] = ^(info & MASK);
  end

  assign chk_o = {(^info) ^ (^ham), ham};
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker import ecc_ctl_pkg::*; (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CHK_W-1:0]  chk_i,
  output err_cls_e          cls_o,
  output logic [DATA_W-1:0] corr_o
);
  logic [CHK_W-1:0] recomp;
  logic [HAM_W-1:0] syn;
  logic             par;
  logic [2:0]       hi;
  logic [HAM_W-1:0] bit_idx;
  logic             pow2;

  ecc_encoder u_enc (.data_i(data_i), .idx_i(idx_i), .chk_o(recomp));

  assign syn  = recomp[HAM_W-1:0] ^ chk_i[HAM_W-1:0];
  assign par  = ^{data_i, idx_i, chk_i};
  assign pow2 = (syn & (syn - 8'd1)) == '0;

  always_comb begin
    hi = '0;
    for (int b = 0; b < HAM_W; b++) if (syn[b]) hi = 3'(b);
  end

  // position -> info index: skip the powers of two below it
  assign bit_idx = syn - 8'd2 - {5'd0, hi};

  always_comb begin
    cls_o  = ERR_NONE;
    corr_o = data_i;
    if (!par) begin
      if (syn != '0) cls_o = ERR_DED;
    end else if (pow2) begin
      cls_o = ERR_CHK;
    end else if (int'(syn) > MAX_POS) begin
      cls_o = ERR_DED;
    end else if (int'(bit_idx) < DATA_W) begin
      cls_o = ERR_DATA;
      corr_o[bit_idx[6:0]] = ~data_i[bit_idx[6:0]];
    end else begin
      cls_o = ERR_ADDR;
    end
  end
endmodule

// File: rtl/ecc_region_gate.sv
module ecc_region_gate import ecc_ctl_pkg::*; #(
  parameter int REGION_W   = 20,
  parameter int REGION_LSB = 17
) (
  input  logic [2:0]          mode_i,
  input  logic [REGION_W-1:0] region_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                prot_o
);
  localparam int SEL_W = ADDR_W - REGION_LSB;
  localparam int EXT_W = 2 ** SEL_W;

  logic [SEL_W-1:0] sel;
  logic [EXT_W-1:0] en_ext;

  assign sel    = addr_i[ADDR_W-1:REGION_LSB];
  assign en_ext = EXT_W'(region_en_i);
  assign prot_o = (mode_i == MODE_FULL) || ((mode_i == MODE_REGION) && en_ext[sel]);
endmodule

// File: rtl/ecc_sram_ctl.sv
module ecc_sram_ctl import ecc_ctl_pkg::*; #(
  parameter int REGION_W   = 20,
  parameter int REGION_LSB = 17
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [BE_W-1:0]     req_be_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  input  logic [2:0]          mode_i,
  input  logic [REGION_W-1:0] region_en_i,
  input  logic                auto_corr_i,
  input  logic                err_resp_en_i,
  output logic                sram_req_o,
  output logic                sram_we_o,
  output logic [1:0]          sram_wsel_o,
  output logic [IDX_W-1:0]    sram_addr_o,
  output logic [WORD_W-1:0]   sram_wdata_o,
  input  logic [WORD_W-1:0]   sram_rdata_i,
  output logic                err_data_o,
  output logic                err_addr_o,
  output logic                err_chk_o,
  output logic                err_ded_o,
  output logic [IDX_W-1:0]    err_idx_o
);
  ctl_st_e           st_q;
  logic              we_q, prot_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] data_q;
  err_cls_e          cls_q;

  logic              prot_in, full_wr;
  err_cls_e          raw_cls, chk_cls;
  logic [DATA_W-1:0] corr_data, chk_data, merged;
  logic [CHK_W-1:0]  enc_chk;
  logic              need_wb;

  ecc_region_gate #(.REGION_W(REGION_W), .REGION_LSB(REGION_LSB)) u_gate (
    .mode_i(mode_i), .region_en_i(region_en_i), .addr_i(req_addr_i), .prot_o(prot_in)
  );

  ecc_checker u_chk (
    .data_i(sram_rdata_i[DATA_W-1:0]), .idx_i(idx_q),
    .chk_i(sram_rdata_i[WORD_W-1:DATA_W]), .cls_o(raw_cls), .corr_o(corr_data)
  );

  ecc_encoder u_enc (.data_i(data_q), .idx_i(idx_q), .chk_o(enc_chk));

  assign full_wr  = (&req_be_i) && (req_addr_i[LSB_W-1:0] == '0);
  assign chk_cls  = prot_q ? raw_cls : ERR_NONE;
  assign chk_data = prot_q ? corr_data : sram_rdata_i[DATA_W-1:0];
  assign need_wb  = (chk_cls == ERR_ADDR) || (chk_cls == ERR_CHK) ||
                    ((chk_cls == ERR_DATA) && auto_corr_i);

  for (genvar b = 0; b < BE_W; b++) begin : g_merge
    assign merged[8*b +: 8] = be_q[b] ? data_q[8*b +: 8] : chk_data[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      prot_q <= 1'b0;
      idx_q  <= '0;
      be_q   <= '0;
      data_q <= '0;
      cls_q  <= ERR_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          we_q   <= req_we_i;
          prot_q <= prot_in;
          idx_q  <= req_addr_i[ADDR_W-1:LSB_W];
          be_q   <= req_be_i;
          data_q <= req_wdata_i;
          cls_q  <= ERR_NONE;
          st_q   <= (req_we_i && full_wr) ? ST_WRITE : ST_READ;
        end
        ST_READ:  st_q <= ST_CHECK;
        ST_CHECK: begin
          if (we_q) begin
            data_q <= merged;
            st_q   <= ST_WRITE;
          end else begin
            data_q <= chk_data;
            cls_q  <= chk_cls;
            st_q   <= need_wb ? ST_WBACK : ST_RESP;
          end
        end
        ST_WRITE, ST_WBACK: st_q <= ST_RESP;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign sram_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE) || (st_q == ST_WBACK);
  assign sram_we_o    = (st_q == ST_WRITE) || (st_q == ST_WBACK);
  assign sram_addr_o  = idx_q;
  assign sram_wsel_o  = ((st_q == ST_WBACK) && (cls_q != ERR_DATA)) ? 2'b10 : 2'b11;
  assign sram_wdata_o = {(prot_q ? enc_chk : {CHK_W{1'b0}}), data_q};

  assign rsp_valid_o  = (st_q == ST_RESP);
  assign rsp_rdata_o  = we_q ? '0 : data_q;
  assign rsp_err_o    = rsp_valid_o && !we_q && (cls_q == ERR_DED) && err_resp_en_i;

  assign err_data_o   = (st_q == ST_CHECK) && (chk_cls == ERR_DATA);
  assign err_addr_o   = (st_q == ST_CHECK) && (chk_cls == ERR_ADDR);
  assign err_chk_o    = (st_q == ST_CHECK) && (chk_cls == ERR_CHK);
  assign err_ded_o    = (st_q == ST_CHECK) && (chk_cls == ERR_DED);
  assign err_idx_o    = idx_q;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o); // R11
  AST_RMW_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o && !sram_we_o && we_q) |=> ##1 (sram_req_o && sram_we_o && sram_wsel_o == 2'b11)); // R2
  AST_DED_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_ded_o && !we_q) |=> !(sram_req_o && sram_we_o)); // R7
  AST_CHK_ONLY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_o && sram_wsel_o == 2'b10) |-> $past(err_addr_o || err_chk_o)); // R6
  AST_UNPROT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_o && !prot_q) |-> sram_wdata_o[WORD_W-1:DATA_W] == '0); // R10
  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_data_o, err_addr_o, err_chk_o, err_ded_o})); // R4
  AST_DATA_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_data_o && !we_q && auto_corr_i) |=> (sram_we_o && sram_wsel_o == 2'b11)); // R4
endmodule

// File: tb/ecc_sram_ctl_tb_top.sv
module ecc_sram_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [21:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [15:0]  req_be = '0;
  logic         req_ready, rsp_valid, rsp_err;
  logic [127:0] rsp_rdata;
  logic [2:0]   mode = 3'd2;
  logic [19:0]  region_en = '0;
  logic         auto_corr = 1'b1, err_resp_en = 1'b1;
  logic         sram_req, sram_we;
  logic [1:0]   sram_wsel;
  logic [17:0]  sram_addr;
  logic [136:0] sram_wdata;
  logic [136:0] sram_rdata = '0;
  logic         e_data, e_addr, e_chk, e_ded;
  logic [17:0]  e_idx;

  ecc_sram_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mode_i(mode), .region_en_i(region_en), .auto_corr_i(auto_corr),
    .err_resp_en_i(err_resp_en),
    .sram_req_o(sram_req), .sram_we_o(sram_we), .sram_wsel_o(sram_wsel),
    .sram_addr_o(sram_addr), .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata),
    .err_data_o(e_data), .err_addr_o(e_addr), .err_chk_o(e_chk), .err_ded_o(e_ded),
    .err_idx_o(e_idx)
  );

  // behavioural SRAM, read latency 1
  logic [136:0] mem [int];
  logic [136:0] wv;
  int wr_cnt = 0, n_data = 0, n_addr = 0, n_chk = 0, n_ded = 0, n_access = 0;
  logic [1:0] last_wsel = '0;

  function automatic logic [136:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  always @(posedge clk) begin
    if (e_data) n_data++;
    if (e_addr) n_addr++;
    if (e_chk)  n_chk++;
    if (e_ded)  n_ded++;
    if (sram_req) begin
      n_access++;
      if (sram_we) begin
        wv = mem_rd(int'(sram_addr));
        if (sram_wsel[0]) wv[127:0]   = sram_wdata[127:0];
        if (sram_wsel[1]) wv[136:128] = sram_wdata[136:128];
        mem[int'(sram_addr)] = wv;
        wr_cnt++;
        last_wsel = sram_wsel;
      end else begin
        sram_rdata <= mem_rd(int'(sram_addr));
      end
    end
  end

  // independent SECDED model
  function automatic logic [8:0] tb_chk(input logic [127:0] d, input logic [17:0] a);
    logic [145:0] info;
    logic [8:0]   c;
    int k;
    info = {a, d};
    c = '0;
    k = 0;
    for (int p = 1; p <= 154; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64 && p != 128) begin
        for (int j = 0; j < 8; j++) if (p[j]) c[j] = c[j] ^ info[k];
        k++;
      end
    end
    c[8] = ^{info, c[7:0]};
    return c;
  endfunction

  function automatic logic [127:0] pat(input int s);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[32*w +: 32] = 32'(s) * 32'h9E3779B1 + 32'(w) * 32'h01234567;
    return r;
  endfunction

  int tests = 0, fails = 0;
  logic [127:0] got_data;
  logic         got_err, got_busy;
  int           got_lat;

  task automatic check(input bit ok, input string req, input logic [136:0] act, input logic [136:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [21:0] a, input logic [127:0] d,
                        input logic [15:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_busy = req_ready;
    got_lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      got_lat++;
    end
    got_data = rsp_rdata;
    got_err  = rsp_err;
  endtask

  localparam int NV = 6;
  localparam logic [21:0] V_ADDR [NV] = '{22'h000100, 22'h000100, 22'h000108,
                                         22'h3FFFF0, 22'h3FFFF0, 22'h020000};
  localparam logic [15:0] V_BE   [NV] = '{16'hFFFF, 16'h00F0, 16'hFFFF,
                                         16'hFFFF, 16'h0001, 16'h8000};

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    fails++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] d, old, mrg;
    logic [17:0]  ix;
    int w0, c0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !sram_req, "R11 reset state",
          {134'd0, req_ready, rsp_valid, sram_req}, 137'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(n_access == 0, "R11 no access after reset", 137'(n_access), 137'd0);

    // table: write then read back
    for (int v = 0; v < NV; v++) begin
      ix  = V_ADDR[v][21:4];
      d   = pat(v + 1);
      old = mem_rd(int'(ix)) [127:0];
      for (int b = 0; b < 16; b++) mrg[8*b +: 8] = V_BE[v][b] ? d[8*b +: 8] : old[8*b +: 8];
      do_req(1'b1, V_ADDR[v], d, V_BE[v]);
      if (V_BE[v] == 16'hFFFF && V_ADDR[v][3:0] == 4'd0)
        check(got_lat == 2, "R1 full write latency", 137'(got_lat), 137'd2);
      else
        check(got_lat == 4, "R2 merge write latency", 137'(got_lat), 137'd4);
      check(mem_rd(int'(ix)) == {tb_chk(mrg, ix), mrg}, "R1/R2 stored word",
            mem_rd(int'(ix)), {tb_chk(mrg, ix), mrg});
      check(got_busy == 1'b0, "R11 busy after accept", 137'(got_busy), 137'd0);
      w0 = wr_cnt; c0 = n_data + n_addr + n_chk + n_ded;
      do_req(1'b0, V_ADDR[v], '0, '0);
      check(got_data == mrg && got_lat == 3, "R3 clean read", {got_data, 9'(got_lat)}, {mrg, 9'd3});
      check(wr_cnt == w0 && (n_data + n_addr + n_chk + n_ded) == c0, "R3 no write no pulse",
            137'(wr_cnt - w0), 137'd0);
    end

    // single data error with repair (R4)
    d = pat(40);
    do_req(1'b1, 22'h000200, d, 16'hFFFF);
    mem[32'h20][77] = ~mem[32'h20][77];
    c0 = n_data; w0 = wr_cnt;
    do_req(1'b0, 22'h000200, '0, '0);
    check(got_data == d, "R4 corrected data", 137'(got_data), 137'(d));
    check(n_data == c0 + 1 && wr_cnt == w0 + 1 && last_wsel == 2'b11, "R4 pulse and repair",
          {129'd0, 2'(n_data - c0), 2'(wr_cnt - w0), last_wsel}, {129'd0, 2'd1, 2'd1, 2'b11});
    check(mem_rd(32'h20) == {tb_chk(d, 18'h20), d}, "R4 memory repaired",
          mem_rd(32'h20), {tb_chk(d, 18'h20), d});

    // without repair (R5)
    auto_corr = 1'b0;
    mem[32'h20][3] = ~mem[32'h20][3];
    wv = mem_rd(32'h20);
    w0 = wr_cnt;
    do_req(1'b0, 22'h000200, '0, '0);
    check(got_data == d, "R5 corrected data", 137'(got_data), 137'(d));
    check(wr_cnt == w0 && mem_rd(32'h20) == wv, "R5 no writeback", mem_rd(32'h20), wv);
    auto_corr = 1'b1;
    mem[32'h20] = {tb_chk(d, 18'h20), d};

    // check-bit error (R6)
    mem[32'h20][130] = ~mem[32'h20][130];
    c0 = n_chk; w0 = wr_cnt;
    do_req(1'b0, 22'h000200, '0, '0);
    check(got_data == d && n_chk == c0 + 1, "R6 check-bit error", 137'(got_data), 137'(d));
    check(wr_cnt == w0 + 1 && last_wsel == 2'b10 && mem_rd(32'h20) == {tb_chk(d, 18'h20), d},
          "R6 check-only rewrite", mem_rd(32'h20), {tb_chk(d, 18'h20), d});

    // address error: word stored at index 1 appears at index 3 (R6)
    d = pat(41);
    do_req(1'b1, 22'h000010, d, 16'hFFFF);
    mem[3] = mem[1];
    c0 = n_addr;
    do_req(1'b0, 22'h000030, '0, '0);
    check(got_data == d && n_addr == c0 + 1, "R6 address error", 137'(n_addr - c0), 137'd1);
    check(mem_rd(3) == {tb_chk(d, 18'd3), d} && last_wsel == 2'b10, "R6 address rewrite",
          mem_rd(3), {tb_chk(d, 18'd3), d});

    // double error (R7, R8)
    mem[32'h20][5] = ~mem[32'h20][5];
    mem[32'h20][90] = ~mem[32'h20][90];
    wv = mem_rd(32'h20);
    c0 = n_ded; w0 = wr_cnt;
    do_req(1'b0, 22'h000200, '0, '0);
    check(got_data == wv[127:0] && n_ded == c0 + 1, "R7 raw data on double", 137'(got_data), wv);
    check(wr_cnt == w0 && mem_rd(32'h20) == wv, "R7 no update", mem_rd(32'h20), wv);
    check(got_err == 1'b1, "R8 error response enabled", 137'(got_err), 137'd1);
    err_resp_en = 1'b0;
    do_req(1'b0, 22'h000200, '0, '0);
    check(got_err == 1'b0, "R8 error response disabled", 137'(got_err), 137'd0);
    err_resp_en = 1'b1;

    // region mode (R9, R10)
    mode = 3'd3; region_en = 20'h00002;
    d = pat(50);
    do_req(1'b1, 22'h020040, d, 16'hFFFF);
    check(mem_rd(32'h2004) == {tb_chk(d, 18'h2004), d}, "R9 region enabled",
          mem_rd(32'h2004), {tb_chk(d, 18'h2004), d});
    do_req(1'b1, 22'h040040, d, 16'hFFFF);
    check(mem_rd(32'h4004) == {9'd0, d}, "R10 zero check unprotected",
          mem_rd(32'h4004), {9'd0, d});
    mem[32'h4004][9] = ~mem[32'h4004][9];
    wv = mem_rd(32'h4004);
    c0 = n_data + n_addr + n_chk + n_ded;
    do_req(1'b0, 22'h040040, '0, '0);
    check(got_data == wv[127:0] && (n_data + n_addr + n_chk + n_ded) == c0,
          "R10 unchecked read", 137'(got_data), wv);
    mode = 3'd0;
    do_req(1'b1, 22'h000300, d, 16'hFFFF);
    check(mem_rd(32'h30) == {9'd0, d}, "R9 mode off", mem_rd(32'h30), {9'd0, d});
    mode = 3'd2;
    do_req(1'b1, 22'h040050, d, 16'hFFFF);
    check(mem_rd(32'h4005) == {tb_chk(d, 18'h4005), d}, "R9 full mode",
          mem_rd(32'h4005), {tb_chk(d, 18'h4005), d});

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule